// File: doc/BRIEF.md
# Configurable Endianness Data Lane Steering

This block sits between a 32-bit processor load/store unit and a 32-bit data bus whose byte lanes are wired little-endian: lane k (bits 8k+7:8k) carries the byte at word offset k. For each data access it computes the bus address, the byte strobes and the lane-placed write data. For each load response it pulls the addressed bytes off the lanes, reorders them if needed and zero- or sign-extends the result. The current data byte order is one of three modes: little-endian, byte-invariant big-endian, or word-invariant big-endian.

Byte-invariant big-endian keeps every byte address as issued and reverses the bytes of halfword and word values. The lowest-addressed byte therefore becomes the most significant byte. Word-invariant big-endian leaves aligned words exactly as in little-endian mode. It mirrors byte and halfword addresses within the word and rejects any misaligned access. The mode is loaded from a configuration pin while reset is held. It can be changed later by a set-mode request. The instruction-fetch path bypasses all of this and is always little-endian.

Top module: `endian_lane_steer`

## Requirements
- R1: While `rst_n` is low the mode is loaded from `cfg_big_i`. A 0 gives little-endian and a 1 gives the big-endian mode named by parameter `RESET_BIG_MODE` (default byte-invariant). `mode_o` reports the mode as 00 little-endian, 01 byte-invariant big-endian, 10 word-invariant big-endian.
- R2: A cycle with `set_req_i` high and `set_mode_i` in {00,01,10} changes `mode_o` to that code from the next cycle on. An access presented in the same cycle as the request uses the old mode. Code 11 is ignored and leaves the mode unchanged.
- R3: Size codes are 00 byte, 01 halfword, 10 word. In little-endian mode, an access at word offset k drives lanes k and upward, and strobe bit k is the lowest strobe set. The value's least significant byte goes on lane k, and `bus_addr_o` equals `acc_addr_i`.
- R4: In byte-invariant big-endian mode, `bus_addr_o` equals `acc_addr_i` and the lanes are those of R3. A halfword puts its most significant byte on the lower lane. A word is fully byte-reversed (value bits 31:24 on lane 0).
- R5: In word-invariant big-endian mode, the low two address bits are XORed with 3 for bytes and with 2 for halfwords, and the lanes follow that mirrored offset. Data bytes are not reordered. An aligned word behaves exactly as in little-endian mode.
- R6: `fault_o` is raised for a valid access when any of these hold: the size code is 11; in word-invariant mode, the access is misaligned (halfword at an odd offset, word at a non-zero offset); in the other modes, the access crosses the word (halfword at offset 3, word at a non-zero offset). A faulting access drives `bus_valid_o` low and the strobes to zero.
- R7: Strobes are set only for write accesses, and write data is zero outside the driven lanes. A valid read is answered one cycle later with `bus_rvalid_i`, and `ld_valid_o` is raised in that cycle. `bus_rvalid_i` with no read issued the cycle before gives no `ld_valid_o`.
- R8: A load result is taken from the lanes and byte order of the access that issued it. With `acc_signed_i` set, a byte or halfword is sign-extended from bit 7 or bit 15; otherwise it is zero-extended.
- R9: A mode change accepted in the cycle a load is issued does not change that load's result.
- R10: `if_bus_addr_o` equals `if_addr_i` and `if_insn_o` equals `if_bus_rdata_i` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_big_i | input | 1 | Reset-time byte order select, 1 = big-endian |
| set_req_i | input | 1 | Runtime mode change request |
| set_mode_i | input | 2 | Requested mode code |
| acc_valid_i | input | 1 | Data access present |
| acc_write_i | input | 1 | 1 = store, 0 = load |
| acc_size_i | input | 2 | 00 byte, 01 halfword, 10 word |
| acc_signed_i | input | 1 | Sign-extend the load result |
| acc_addr_i | input | AW | Byte address of the access |
| acc_wdata_i | input | 32 | Store value, right-justified |
| bus_valid_o | output | 1 | Access issued to the bus |
| bus_write_o | output | 1 | Bus access is a write |
| bus_addr_o | output | AW | Bus byte address |
| bus_wdata_o | output | 32 | Lane-placed write data |
| bus_strb_o | output | 4 | Byte lane write strobes |
| fault_o | output | 1 | Alignment or size fault |
| bus_rvalid_i | input | 1 | Read response valid |
| bus_rdata_i | input | 32 | Read response data |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Extended load result |
| if_addr_i | input | AW | Fetch address from the core |
| if_bus_addr_o | output | AW | Fetch address to the bus |
| if_bus_rdata_i | input | 32 | Fetch data from the bus |
| if_insn_o | output | 32 | Fetch data to the core |
| mode_o | output | 2 | Current data mode |

## Verification
The bench targets the offsets where the modes differ. In word-invariant mode, a halfword at offset 0 must land on the upper lanes. A design that forgot the address mirror would strobe 0011 instead of 1100. A halfword at offset 1 is legal in the other modes but must fault in word-invariant mode, and one at offset 3 must fault in every mode. A design that reversed bytes in the wrong mode would return values such as D5C6 where C6D5 is due. The bench also changes the mode in the same cycle as a store and as a load issue. A design that applied the new mode too early would move the store's lanes or corrupt the in-flight load.

// File: rtl/endian_lane_steer.sv
module endian_lane_steer #(
  parameter int          AW             = 32,
  parameter logic [1:0]  RESET_BIG_MODE = 2'b01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_big_i,
  input  logic          set_req_i,
  input  logic [1:0]    set_mode_i,
  input  logic          acc_valid_i,
  input  logic          acc_write_i,
  input  logic [1:0]    acc_size_i,
  input  logic          acc_signed_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [31:0]   acc_wdata_i,
  output logic          bus_valid_o,
  output logic          bus_write_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [31:0]   bus_wdata_o,
  output logic [3:0]    bus_strb_o,
  output logic          fault_o,
  input  logic          bus_rvalid_i,
  input  logic [31:0]   bus_rdata_i,
  output logic          ld_valid_o,
  output logic [31:0]   ld_data_o,
  input  logic [AW-1:0] if_addr_i,
  output logic [AW-1:0] if_bus_addr_o,
  input  logic [31:0]   if_bus_rdata_i,
  output logic [31:0]   if_insn_o,
  output logic [1:0]    mode_o
);

  localparam logic [1:0] M_LE   = 2'b00;
  localparam logic [1:0] M_BYTE = 2'b01;
  localparam logic [1:0] M_WORD = 2'b10;
  localparam logic [1:0] SZ_B   = 2'b00;
  localparam logic [1:0] SZ_H   = 2'b01;
  localparam logic [1:0] SZ_W   = 2'b10;

  logic [1:0] mode_q;
  logic       pend_q;
  logic [1:0] m_off_q;
  logic [1:0] m_size_q;
  logic       m_sgn_q;
  logic       m_rev_q;

  // Keep the low bytes of a value by size, optionally reversing their order.
  function automatic logic [31:0] fit(input logic [31:0] v, input logic [1:0] sz, input logic rev);
    logic [31:0] r;
    case (sz)
      SZ_B:    r = {24'h0, v[7:0]};
      SZ_H:    r = rev ? {16'h0, v[7:0], v[15:8]} : {16'h0, v[15:0]};
      default: r = rev ? {v[7:0], v[15:8], v[23:16], v[31:24]} : v;
    endcase
    return r;
  endfunction

  logic [1:0] off;
  logic       misal;
  logic       crosses;
  logic       go;
  logic [1:0] lane_off;
  logic [3:0] strb_base;
  logic       rev_now;

  assign off     = acc_addr_i[1:0];
  assign misal   = (acc_size_i == SZ_H && off[0]) || (acc_size_i == SZ_W && off != 2'd0);
  assign crosses = (acc_size_i == SZ_H && off == 2'd3) || (acc_size_i == SZ_W && off != 2'd0);
  assign rev_now = (mode_q == M_BYTE);

  assign fault_o = acc_valid_i &&
                   ((acc_size_i == 2'b11) || ((mode_q == M_WORD) ? misal : crosses));
  assign go      = acc_valid_i && !fault_o;

  always_comb begin
    lane_off = off;
    if (mode_q == M_WORD) begin
      case (acc_size_i)
        SZ_B:    lane_off = off ^ 2'd3;
        SZ_H:    lane_off = off ^ 2'd2;
        default: lane_off = 2'd0;
      endcase
    end
  end

  always_comb begin
    case (acc_size_i)
      SZ_B:    strb_base = 4'b0001;
      SZ_H:    strb_base = 4'b0011;
      default: strb_base = 4'b1111;
    endcase
  end

  assign bus_valid_o = go;
  assign bus_write_o = go && acc_write_i;
  assign bus_addr_o  = {acc_addr_i[AW-1:2], lane_off};
  assign bus_strb_o  = bus_write_o ? (strb_base << lane_off) : 4'b0000;
  assign bus_wdata_o = bus_write_o ? (fit(acc_wdata_i, acc_size_i, rev_now) << {lane_off, 3'b000})
                                   : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= cfg_big_i ? RESET_BIG_MODE : M_LE;
      pend_q   <= 1'b0;
      m_off_q  <= 2'd0;
      m_size_q <= SZ_W;
      m_sgn_q  <= 1'b0;
      m_rev_q  <= 1'b0;
    end else begin
      if (set_req_i && set_mode_i != 2'b11) mode_q <= set_mode_i;
      pend_q <= go && !acc_write_i;
      if (go && !acc_write_i) begin
        m_off_q  <= lane_off;
        m_size_q <= acc_size_i;
        m_sgn_q  <= acc_signed_i;
        m_rev_q  <= rev_now;
      end
    end
  end

  logic [31:0] rd_fit;
  assign rd_fit = fit(bus_rdata_i >> {m_off_q, 3'b000}, m_size_q, m_rev_q);

  always_comb begin
    case (m_size_q)
      SZ_B:    ld_data_o = {{24{m_sgn_q & rd_fit[7]}}, rd_fit[7:0]};
      SZ_H:    ld_data_o = {{16{m_sgn_q & rd_fit[15]}}, rd_fit[15:0]};
      default: ld_data_o = rd_fit;
    endcase
  end

  assign ld_valid_o    = pend_q && bus_rvalid_i;
  assign if_bus_addr_o = if_addr_i;
  assign if_insn_o     = if_bus_rdata_i;
  assign mode_o        = mode_q;

endmodule

// File: rtl/endian_lane_steer_chk.sv
module endian_lane_steer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          set_req_i,
  input logic [1:0]    set_mode_i,
  input logic          acc_valid_i,
  input logic          acc_write_i,
  input logic [1:0]    acc_size_i,
  input logic [AW-1:0] acc_addr_i,
  input logic [31:0]   acc_wdata_i,
  input logic          bus_valid_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [31:0]   bus_wdata_o,
  input logic [3:0]    bus_strb_o,
  input logic          fault_o,
  input logic          bus_rvalid_i,
  input logic          ld_valid_o,
  input logic [1:0]    mode_o
);

  a_r2_mode_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req_i && set_mode_i != 2'b11) |=> (mode_o == $past(set_mode_i)));

  a_r2_illegal_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req_i && set_mode_i == 2'b11) |=> $stable(mode_o));

  a_r3_strobe_count: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && acc_write_i) |->
      ($countones(bus_strb_o) == ((acc_size_i == 2'b00) ? 1 : (acc_size_i == 2'b01) ? 2 : 4)));

  a_r4_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && mode_o == 2'b01) |-> (bus_addr_o == acc_addr_i));

  a_r5_word_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && mode_o == 2'b10 && acc_size_i == 2'b10) |->
      (bus_addr_o == acc_addr_i && (!acc_write_i || bus_wdata_o == acc_wdata_i)));

  a_r6_misaligned_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && mode_o == 2'b10 &&
     ((acc_size_i == 2'b01 && acc_addr_i[0]) || (acc_size_i == 2'b10 && acc_addr_i[1:0] != 2'b00)))
      |-> fault_o);

  a_r6_fault_blocks_bus: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!bus_valid_o && bus_strb_o == 4'b0000));

  a_r7_load_needs_response: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_o |-> bus_rvalid_i);

endmodule

bind endian_lane_steer endian_lane_steer_chk #(.AW(AW)) chk (.*);

// File: tb/endian_lane_steer_test.sv
`timescale 1ns/1ps
module endian_lane_steer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big_i = 1'b0;
  logic        set_req_i = 1'b0;
  logic [1:0]  set_mode_i = 2'b00;
  logic        acc_valid_i = 1'b0;
  logic        acc_write_i = 1'b0;
  logic [1:0]  acc_size_i = 2'b00;
  logic        acc_signed_i = 1'b0;
  logic [31:0] acc_addr_i = 32'h0;
  logic [31:0] acc_wdata_i = 32'h0;
  logic        bus_valid_o, bus_write_o, fault_o, ld_valid_o;
  logic [31:0] bus_addr_o, bus_wdata_o, ld_data_o, if_bus_addr_o, if_insn_o;
  logic [3:0]  bus_strb_o;
  logic        bus_rvalid_i = 1'b0;
  logic [31:0] bus_rdata_i = 32'h0;
  logic [31:0] if_addr_i = 32'h0;
  logic [31:0] if_bus_rdata_i = 32'h0;
  logic [1:0]  mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  endian_lane_steer uut (.*);

  // store vector: {mode, size, offset, exp_addr_lo, exp_strb, exp_wdata, exp_fault}
  localparam int NS = 18;
  localparam logic [44:0] ST [NS] = '{
    {2'd0, 2'd0, 2'd1, 2'd1, 4'b0010, 32'h0000_4400, 1'b0},
    {2'd0, 2'd1, 2'd2, 2'd2, 4'b1100, 32'h3344_0000, 1'b0},
    {2'd0, 2'd1, 2'd1, 2'd1, 4'b0110, 32'h0033_4400, 1'b0},
    {2'd0, 2'd2, 2'd0, 2'd0, 4'b1111, 32'h1122_3344, 1'b0},
    {2'd0, 2'd2, 2'd2, 2'd0, 4'b0000, 32'h0,         1'b1},
    {2'd0, 2'd1, 2'd3, 2'd0, 4'b0000, 32'h0,         1'b1},
    {2'd0, 2'd3, 2'd0, 2'd0, 4'b0000, 32'h0,         1'b1},
    {2'd1, 2'd0, 2'd3, 2'd3, 4'b1000, 32'h4400_0000, 1'b0},
    {2'd1, 2'd1, 2'd0, 2'd0, 4'b0011, 32'h0000_4433, 1'b0},
    {2'd1, 2'd1, 2'd1, 2'd1, 4'b0110, 32'h0044_3300, 1'b0},
    {2'd1, 2'd2, 2'd0, 2'd0, 4'b1111, 32'h4433_2211, 1'b0},
    {2'd2, 2'd0, 2'd0, 2'd3, 4'b1000, 32'h4400_0000, 1'b0},
    {2'd2, 2'd0, 2'd2, 2'd1, 4'b0010, 32'h0000_4400, 1'b0},
    {2'd2, 2'd1, 2'd0, 2'd2, 4'b1100, 32'h3344_0000, 1'b0},
    {2'd2, 2'd1, 2'd2, 2'd0, 4'b0011, 32'h0000_3344, 1'b0},
    {2'd2, 2'd2, 2'd0, 2'd0, 4'b1111, 32'h1122_3344, 1'b0},
    {2'd2, 2'd1, 2'd1, 2'd0, 4'b0000, 32'h0,         1'b1},
    {2'd2, 2'd2, 2'd2, 2'd0, 4'b0000, 32'h0,         1'b1}
  };

  // load vector: {mode, size, signed, offset, expected}, bus data 8A7BC6D5
  localparam int NL = 15;
  localparam logic [38:0] LD [NL] = '{
    {2'd0, 2'd0, 1'b0, 2'd0, 32'h0000_00D5},
    {2'd0, 2'd0, 1'b1, 2'd0, 32'hFFFF_FFD5},
    {2'd0, 2'd0, 1'b1, 2'd2, 32'h0000_007B},
    {2'd0, 2'd1, 1'b1, 2'd0, 32'hFFFF_C6D5},
    {2'd0, 2'd1, 1'b0, 2'd1, 32'h0000_7BC6},
    {2'd0, 2'd2, 1'b0, 2'd0, 32'h8A7B_C6D5},
    {2'd1, 2'd1, 1'b0, 2'd0, 32'h0000_D5C6},
    {2'd1, 2'd1, 1'b1, 2'd0, 32'hFFFF_D5C6},
    {2'd1, 2'd1, 1'b1, 2'd2, 32'h0000_7B8A},
    {2'd1, 2'd2, 1'b0, 2'd0, 32'hD5C6_7B8A},
    {2'd1, 2'd0, 1'b1, 2'd3, 32'hFFFF_FF8A},
    {2'd2, 2'd0, 1'b0, 2'd0, 32'h0000_008A},
    {2'd2, 2'd0, 1'b1, 2'd3, 32'hFFFF_FFD5},
    {2'd2, 2'd1, 1'b1, 2'd0, 32'hFFFF_8A7B},
    {2'd2, 2'd1, 1'b0, 2'd2, 32'h0000_C6D5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic cfg);
    @(negedge clk);
    rst_n = 1'b0; cfg_big_i = cfg;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; cfg_big_i = 1'b0;
  endtask

  task automatic go_mode(input logic [1:0] m);
    @(negedge clk);
    set_req_i = 1'b1; set_mode_i = m;
    @(negedge clk);
    set_req_i = 1'b0;
  endtask

  task automatic idle();
    acc_valid_i = 1'b0; acc_write_i = 1'b0; acc_signed_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    do_reset(1'b0);
    #1 check("R1 reset cfg=0 mode", {30'h0, mode_o}, 32'h0);
    do_reset(1'b1);
    #1 check("R1 reset cfg=1 mode", {30'h0, mode_o}, 32'h1);

    for (int i = 0; i < NS; i++) begin
      go_mode(ST[i][44:43]);
      acc_valid_i = 1'b1; acc_write_i = 1'b1;
      acc_size_i  = ST[i][42:41];
      acc_addr_i  = {28'h0001_234, 2'b00, ST[i][40:39]};
      acc_wdata_i = 32'h1122_3344;
      #1;
      check($sformatf("R6 store %0d fault", i), {31'h0, fault_o}, {31'h0, ST[i][0]});
      check($sformatf("R6 store %0d valid", i), {31'h0, bus_valid_o}, {31'h0, !ST[i][0]});
      check($sformatf("R3 R4 R5 store %0d strb", i), {28'h0, bus_strb_o}, {28'h0, ST[i][36:33]});
      if (!ST[i][0]) begin
        check($sformatf("R3 R4 R5 store %0d data", i), bus_wdata_o, ST[i][32:1]);
        check($sformatf("R3 R4 R5 store %0d addr", i), bus_addr_o, {28'h0001_234, 2'b00, ST[i][38:37]});
      end
      @(negedge clk);
      idle();
    end

    for (int i = 0; i < NL; i++) begin
      go_mode(LD[i][38:37]);
      acc_valid_i = 1'b1; acc_write_i = 1'b0;
      acc_size_i   = LD[i][36:35];
      acc_signed_i = LD[i][34];
      acc_addr_i   = {30'h0, LD[i][33:32]};
      #1 check($sformatf("R7 load %0d no strobe", i), {28'h0, bus_strb_o}, 32'h0);
      @(negedge clk);
      idle();
      bus_rvalid_i = 1'b1; bus_rdata_i = 32'h8A7B_C6D5;
      #1;
      check($sformatf("R7 load %0d valid", i), {31'h0, ld_valid_o}, 32'h1);
      check($sformatf("R8 load %0d data", i), ld_data_o, LD[i][31:0]);
      @(negedge clk);
      bus_rvalid_i = 1'b0;
    end

    // R7: response without a preceding read
    @(negedge clk);
    bus_rvalid_i = 1'b1;
    #1 check("R7 stray response ignored", {31'h0, ld_valid_o}, 32'h0);
    @(negedge clk);
    bus_rvalid_i = 1'b0;

    // R2: illegal code ignored
    go_mode(2'b10);
    go_mode(2'b11);
    #1 check("R2 code 11 ignored", {30'h0, mode_o}, 32'h2);

    // R2: store in same cycle as a change uses old (word-invariant) mode
    @(negedge clk);
    set_req_i = 1'b1; set_mode_i = 2'b00;
    acc_valid_i = 1'b1; acc_write_i = 1'b1; acc_size_i = 2'b00;
    acc_addr_i = 32'h0000_0100; acc_wdata_i = 32'h0000_005A;
    #1;
    check("R2 same-cycle store addr", bus_addr_o, 32'h0000_0103);
    check("R2 same-cycle store strb", {28'h0, bus_strb_o}, 32'h8);
    @(negedge clk);
    set_req_i = 1'b0; idle();
    #1 check("R2 mode after change", {30'h0, mode_o}, 32'h0);

    // R9: load issued with a change in the same cycle keeps its mode
    go_mode(2'b10);
    @(negedge clk);
    set_req_i = 1'b1; set_mode_i = 2'b01;
    acc_valid_i = 1'b1; acc_write_i = 1'b0; acc_size_i = 2'b00; acc_signed_i = 1'b0;
    acc_addr_i = 32'h0;
    @(negedge clk);
    set_req_i = 1'b0; idle();
    bus_rvalid_i = 1'b1; bus_rdata_i = 32'h8A7B_C6D5;
    #1;
    check("R9 in-flight mode", {30'h0, mode_o}, 32'h1);
    check("R9 in-flight load data", ld_data_o, 32'h0000_008A);
    @(negedge clk);
    bus_rvalid_i = 1'b0;

    // R10: fetch passthrough in every mode
    for (int m = 0; m < 3; m++) begin
      go_mode(m[1:0]);
      if_addr_i = 32'h0000_2001 + m;
      if_bus_rdata_i = 32'hA1B2_C3D4 ^ m;
      #1;
      check("R10 fetch addr", if_bus_addr_o, 32'h0000_2001 + m);
      check("R10 fetch data", if_insn_o, 32'hA1B2_C3D4 ^ m);
    end

    finish_run();
  end

endmodule